// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver Cell

This block carries a WIDTH-bit word (18 bits by default) between two ports, called A and B. It has one path in each direction. Each path has a pass control, a strobe and an output-enable request. For each path the pass control and the strobe pick one of three behaviours:

- **Pass:** the word flows straight through the same cycle.
- **Hold:** the stored word stays as it is.
- **Capture:** the word is stored on a rising strobe.

The A-to-B drive request is active high. The B-to-A drive request is active low.

The whole cell runs on one fast system clock. Each strobe is sampled on that clock, and a rise is seen when the previous sample was 0 and the current one is 1. The sample register comes out of reset at 1, so a strobe that is already high when reset is released does not count as a rise.

No real tri-state pad is modelled. Each port gives a data value and a drive flag. A keeper per port remembers the last value that an outside agent drove onto it. While that port is released, its keeper value, and not the raw input, feeds the path that reads the port.

Top module: `bus_xcvr_cell`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both stored words and both keepers to zero. After reset, with pass low, a_out, b_out, a_keep and b_keep all read 0.
- R2: While ab_pass is 1, b_out equals the A-side source word in the same cycle. The A-side source word is a_in when a_ext_drv is 1, and a_keep otherwise.
- R3: While ab_pass is 0 and no strobe rise is detected, the A-to-B stored word, and so b_out, does not change.
- R4: When ab_pass is 0 and ab_strobe was sampled 0 at one clock edge and 1 at the next, the A-side source word present at that second edge becomes b_out after it.
- R5: While ab_pass is 1, a strobe rise has no visible effect: b_out keeps following the source word.
- R6: When ab_pass falls, b_out holds the source word from the last clock edge at which ab_pass was 1.
- R7: b_oe equals ab_drive_en (active high). a_oe is the inverse of ba_drive_n (active low).
- R8: Each keeper loads its port input only at edges where that port's ext_drv is 1, and otherwise keeps its value. The path reading a released port uses the keeper value.
- R9: The B-to-A path (ba_pass, ba_strobe, source word from b_in/b_keep, output a_out) obeys R2 to R6 in the same way.
- R11: A strobe held high over several edges captures only once. Changing the input while the strobe stays high does not change the output.
- R10: Both drive flags may be 1 at once. a_out then shows the B-to-A stored word and b_out shows the A-to-B stored word, each independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Level seen on port A from outside |
| a_ext_drv | input | 1 | 1 when an outside agent drives port A |
| b_in | input | WIDTH | Level seen on port B from outside |
| b_ext_drv | input | 1 | 1 when an outside agent drives port B |
| ab_pass | input | 1 | A-to-B pass control (1 = flow-through) |
| ab_strobe | input | 1 | A-to-B strobe; rise captures |
| ab_drive_en | input | 1 | Port B drive request, active high |
| ba_pass | input | 1 | B-to-A pass control (1 = flow-through) |
| ba_strobe | input | 1 | B-to-A strobe; rise captures |
| ba_drive_n | input | 1 | Port A drive request, active low |
| a_out | output | WIDTH | Value the cell presents on port A |
| a_oe | output | 1 | Cell drives port A |
| b_out | output | WIDTH | Value the cell presents on port B |
| b_oe | output | 1 | Cell drives port B |
| a_keep | output | WIDTH | Port A keeper value |
| b_keep | output | WIDTH | Port B keeper value |

## Verification
The checker watches the following on every cycle:
- flow-through while pass is high;
- a stable stored word when neither pass nor a rise is present;
- single-edge capture of the source word;
- strobe rises that always follow a low sample;
- keeper loading and retention;
- the cleared state after reset.

Some behaviours can only be shown by the bench's directed scenarios:
- the value left after pass falls;
- the priority of pass over a simultaneous rise;
- the drive-flag polarities;
- concurrent driving of both ports;
- the path reading the keeper once a port is released.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

  typedef enum logic [1:0] {
    XF_HOLD    = 2'd0,
    XF_PASS    = 2'd1,
    XF_CAPTURE = 2'd2
  } xfer_mode_e;

  // A rise is a 0 sample followed by a 1 sample.
  function automatic logic is_rise(input logic prev_s, input logic cur_s);
    return (~prev_s) & cur_s;
  endfunction

  // Pass wins over a strobe rise; otherwise a rise captures, else hold.
  function automatic xfer_mode_e decode_mode(input logic pass, input logic rise);
    if (pass)      return XF_PASS;
    else if (rise) return XF_CAPTURE;
    else           return XF_HOLD;
  endfunction

endpackage

// File: rtl/bxc_edge_det.sv
module bxc_edge_det #(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  import bxc_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_LEVEL;
    else     prev_q <= lvl;
  end

  assign rise = is_rise(prev_q, lvl);

endmodule

// File: rtl/bxc_keeper.sv
module bxc_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_drv,
  input  logic [W-1:0] pin,
  output logic [W-1:0] keep,
  output logic [W-1:0] seen
);
  logic [W-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (rst)          keep_q <= '0;
    else if (ext_drv) keep_q <= pin;
  end

  assign keep = keep_q;
  assign seen = ext_drv ? pin : keep_q;

endmodule

// File: rtl/bxc_path.sv
module bxc_path #(
  parameter int W             = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pass,
  input  logic               strobe,
  input  logic               oe_req,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout,
  output logic               oe,
  output logic               rise_evt,
  output bxc_pkg::xfer_mode_e mode
);
  import bxc_pkg::*;

  logic [W-1:0] store_q;

  bxc_edge_det #(.RST_LEVEL(1'b1)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (strobe),
    .rise (rise_evt)
  );

  assign mode = decode_mode(pass, rise_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      case (mode)
        XF_PASS, XF_CAPTURE: store_q <= din;
        default:             store_q <= store_q;
      endcase
    end
  end

  assign dout = (mode == XF_PASS) ? din : store_q;

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign oe = ~oe_req;
    end else begin : g_oe_high
      assign oe = oe_req;
    end
  endgenerate

endmodule

// File: rtl/bus_xcvr_cell.sv
module bus_xcvr_cell #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_ext_drv,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_ext_drv,
  input  logic             ab_pass,
  input  logic             ab_strobe,
  input  logic             ab_drive_en,
  input  logic             ba_pass,
  input  logic             ba_strobe,
  input  logic             ba_drive_n,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] a_keep,
  output logic [WIDTH-1:0] b_keep
);
  import bxc_pkg::*;

  localparam int NPORT = 2;   // index 0 = port A, 1 = port B
  localparam int NDIR  = 2;   // index 0 = A to B, 1 = B to A

  logic [NPORT-1:0][WIDTH-1:0] pin_in;
  logic [NPORT-1:0][WIDTH-1:0] keep_w;
  logic [NPORT-1:0][WIDTH-1:0] src_bus;
  logic [NPORT-1:0]            ext_w;

  logic [NDIR-1:0][WIDTH-1:0]  dir_dout;
  logic [NDIR-1:0]             dir_pass, dir_strobe, dir_oe_req, dir_oe, dir_rise;
  xfer_mode_e                  dir_mode [NDIR];

  assign pin_in = {b_in, a_in};
  assign ext_w  = {b_ext_drv, a_ext_drv};

  assign dir_pass   = {ba_pass, ab_pass};
  assign dir_strobe = {ba_strobe, ab_strobe};
  assign dir_oe_req = {ba_drive_n, ab_drive_en};

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      bxc_keeper #(.W(WIDTH)) u_keep (
        .clk     (clk),
        .rst     (rst),
        .ext_drv (ext_w[p]),
        .pin     (pin_in[p]),
        .keep    (keep_w[p]),
        .seen    (src_bus[p])
      );
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      bxc_path #(.W(WIDTH), .OE_ACTIVE_LOW(d == 1)) u_path (
        .clk      (clk),
        .rst      (rst),
        .pass     (dir_pass[d]),
        .strobe   (dir_strobe[d]),
        .oe_req   (dir_oe_req[d]),
        .din      (src_bus[d]),
        .dout     (dir_dout[d]),
        .oe       (dir_oe[d]),
        .rise_evt (dir_rise[d]),
        .mode     (dir_mode[d])
      );
    end
  endgenerate

  assign b_out  = dir_dout[0];
  assign b_oe   = dir_oe[0];
  assign a_out  = dir_dout[1];
  assign a_oe   = dir_oe[1];
  assign a_keep = keep_w[0];
  assign b_keep = keep_w[1];

endmodule

// File: rtl/bxc_checker.sv
module bxc_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         ab_pass,
  input logic         ba_pass,
  input logic         ab_strobe,
  input logic         ab_rise,
  input logic         ba_rise,
  input logic [W-1:0] ab_src,
  input logic [W-1:0] ba_src,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_ext_drv,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_keep,
  input logic [W-1:0] b_keep
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_keep == '0 && b_keep == '0));

  // R2
  ab_flow_chk: assert property (@(posedge clk) disable iff (rst)
    ab_pass |-> (b_out == ab_src));

  // R9
  ba_flow_chk: assert property (@(posedge clk) disable iff (rst)
    ba_pass |-> (a_out == ba_src));

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_rise) |=> (ab_pass || $stable(b_out)));

  // R4
  ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_rise) |=> (ab_pass || b_out == $past(ab_src)));

  // R9
  ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && ba_rise) |=> (ba_pass || a_out == $past(ba_src)));

  // R11
  ab_rise_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ab_rise |=> !ab_rise);

  // R11
  ab_rise_level_chk: assert property (@(posedge clk) disable iff (rst)
    ab_rise |-> ab_strobe);

  // R8
  a_keep_load_chk: assert property (@(posedge clk) disable iff (rst)
    a_ext_drv |=> (a_keep == $past(a_in)));

  // R8
  a_keep_stay_chk: assert property (@(posedge clk) disable iff (rst)
    !a_ext_drv |=> $stable(a_keep));

endmodule

bind bus_xcvr_cell bxc_checker #(.W(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ab_pass   (ab_pass),
  .ba_pass   (ba_pass),
  .ab_strobe (ab_strobe),
  .ab_rise   (dir_rise[0]),
  .ba_rise   (dir_rise[1]),
  .ab_src    (src_bus[0]),
  .ba_src    (src_bus[1]),
  .a_out     (a_out),
  .b_out     (b_out),
  .a_ext_drv (a_ext_drv),
  .a_in      (a_in),
  .a_keep    (a_keep),
  .b_keep    (b_keep)
);

// File: tb/bus_xcvr_cell_tb_top.sv
module bus_xcvr_cell_tb_top;
  localparam int W        = 18;
  localparam int CLK_PER  = 10;
  localparam int WDOG_CYC = 5000;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in;
  logic a_ext_drv, b_ext_drv;
  logic ab_pass, ab_strobe, ab_drive_en;
  logic ba_pass, ba_strobe, ba_drive_n;
  logic [W-1:0] a_out, b_out, a_keep, b_keep;
  logic a_oe, b_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PER/2) clk = ~clk;

  bus_xcvr_cell #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_ext_drv(a_ext_drv),
    .b_in(b_in), .b_ext_drv(b_ext_drv),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive_en(ab_drive_en),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .a_keep(a_keep), .b_keep(b_keep)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive after the falling edge, look 1 time unit later
  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic past_pos();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    a_ext_drv = 1'b1; b_ext_drv = 1'b1;
    ab_pass = 1'b0; ab_strobe = 1'b0; ab_drive_en = 1'b0;
    ba_pass = 1'b0; ba_strobe = 1'b0; ba_drive_n = 1'b1;
    repeat (3) @(posedge clk);
    at_neg();
    rst = 1'b0;
    a_ext_drv = 1'b0; b_ext_drv = 1'b0;
    #1;
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 a_keep", a_keep, '0);
    chk("R1 b_keep", b_keep, '0);
  endtask

  task automatic t_pass_ab();
    at_neg();
    a_ext_drv = 1'b1; a_in = 18'h2A5A5; ab_pass = 1'b1;
    #1 chk("R2 flow first", b_out, 18'h2A5A5);
    at_neg();
    a_in = 18'h15A5A;
    #1 chk("R2 flow second", b_out, 18'h15A5A);
  endtask

  task automatic t_pass_fall();
    // the last edge with pass high stored 15A5A
    at_neg();
    ab_pass = 1'b0; a_in = 18'h3FFFF;
    #1 chk("R6 held after pass falls", b_out, 18'h15A5A);
    past_pos();
    chk("R3 no rise keeps word", b_out, 18'h15A5A);
  endtask

  task automatic t_capture();
    at_neg();
    ab_strobe = 1'b1; a_in = 18'h0C3C3;
    #1 chk("R3 before edge", b_out, 18'h15A5A);
    past_pos();
    chk("R4 capture on rise", b_out, 18'h0C3C3);
    at_neg();
    a_in = 18'h11111;
    past_pos();
    chk("R11 high level no capture", b_out, 18'h0C3C3);
    at_neg();
    ab_strobe = 1'b0;
    past_pos();
    chk("R3 falling strobe holds", b_out, 18'h0C3C3);
    at_neg();
    ab_strobe = 1'b1;
    past_pos();
    chk("R4 second rise captures", b_out, 18'h11111);
    at_neg();
    ab_strobe = 1'b0;
  endtask

  task automatic t_priority();
    at_neg();
    ab_pass = 1'b1; a_in = 18'h00F0F;
    at_neg();
    ab_strobe = 1'b1; a_in = 18'h0F0F0;
    #1 chk("R5 pass over rise", b_out, 18'h0F0F0);
    past_pos();
    chk("R5 still flowing", b_out, 18'h0F0F0);
    at_neg();
    ab_strobe = 1'b0; ab_pass = 1'b0;
  endtask

  task automatic t_enables();
    at_neg();
    ab_drive_en = 1'b0; ba_drive_n = 1'b1;
    #1 chk("R7 b_oe off", {17'd0, b_oe}, 18'd0);
    chk("R7 a_oe off", {17'd0, a_oe}, 18'd0);
    at_neg();
    ab_drive_en = 1'b1; ba_drive_n = 1'b0;
    #1 chk("R7 b_oe on", {17'd0, b_oe}, 18'd1);
    chk("R7 a_oe on", {17'd0, a_oe}, 18'd1);
    at_neg();
    ab_drive_en = 1'b0; ba_drive_n = 1'b1;
  endtask

  task automatic t_keeper();
    at_neg();
    a_ext_drv = 1'b1; a_in = 18'h2468A;
    past_pos();
    chk("R8 keeper loads", a_keep, 18'h2468A);
    at_neg();
    a_ext_drv = 1'b0; a_in = 18'h3FFFF;
    past_pos();
    chk("R8 keeper retains", a_keep, 18'h2468A);
    at_neg();
    ab_pass = 1'b1;
    #1 chk("R8 path reads keeper", b_out, 18'h2468A);
    at_neg();
    ab_pass = 1'b0;
  endtask

  task automatic t_ba_path();
    at_neg();
    b_ext_drv = 1'b1; b_in = 18'h13579; ba_pass = 1'b1;
    #1 chk("R9 B-to-A flow", a_out, 18'h13579);
    at_neg();
    ba_pass = 1'b0; b_in = 18'h0ABCD;
    #1 chk("R9 B-to-A held", a_out, 18'h13579);
    at_neg();
    ba_strobe = 1'b1;
    past_pos();
    chk("R9 B-to-A capture", a_out, 18'h0ABCD);
    chk("R8 b keeper", b_keep, 18'h0ABCD);
    at_neg();
    ba_strobe = 1'b0;
  endtask

  task automatic t_both();
    at_neg();
    ab_drive_en = 1'b1; ba_drive_n = 1'b0;
    b_in = 18'h00001; a_ext_drv = 1'b1; a_in = 18'h3C3C3;
    past_pos();
    chk("R10 a_oe", {17'd0, a_oe}, 18'd1);
    chk("R10 b_oe", {17'd0, b_oe}, 18'd1);
    chk("R10 a_out own path", a_out, 18'h0ABCD);
    chk("R10 b_out own path", b_out, 18'h2468A);
  endtask

  initial begin
    t_reset();
    t_pass_ab();
    t_pass_fall();
    t_capture();
    t_priority();
    t_enables();
    t_keeper();
    t_ba_path();
    t_both();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule